// File: doc/BRIEF.md
# Double-Rate Four-Port Vector Scratchpad

This block is the on-chip data store of a vector engine. On every cycle of the system clock it accepts two source-operand reads, one result write and one access from a DMA engine, which may be a read or a write. It reaches four logical ports from a single two-port RAM that runs on a companion clock at twice the system rate. In the first fast half of each system cycle, both physical ports serve the two source reads. In the second fast half, one physical port takes the result write and the other takes the DMA access.

Callers address the memory with plain byte pointers. Word selection ignores the two low address bits. Bytes and halfwords stay packed inside each 32-bit word, and stores of narrow data use byte-lane enables. Source-read data is registered in the fast domain and handed to the system clock, so both operands appear together one system edge after the request. DMA read data comes back one system cycle later than that, flagged by a valid strobe. When the result write and a DMA write target the same word in the same cycle, the result write goes first. The block keeps the DMA write and replays it on the next cycle, and it lowers its DMA ready output for that cycle.

Top module: `sp_scratch_dp`

## Requirements
- R1: A source read on port a or b with its enable high returns the 32-bit word at byte address bits [AW-1:2] on its data output after the next system clock edge. Address bits [1:0] do not affect which word is read.
- R2: A source read and a result write to the same word in the same system cycle return the word's previous contents. A read in the following cycle returns the new contents.
- R3: Result-write enable bit i controls byte lane i, which is data bits 8i+7 to 8i. Lanes whose enable is low keep their stored value.
- R4: A DMA write that is accepted while dma_ready is high updates only the byte lanes selected by dma_be. The updated word can be read on the source ports in the next cycle.
- R5: A DMA read accepted in cycle C raises dma_rvalid for exactly one cycle after the second system edge that follows C, with the addressed word on dma_rdata.
- R6: When the result write and an accepted DMA write target the same word in the same cycle, the result write is stored in that cycle and dma_ready is low in the next cycle. In that next cycle the DMA bytes are written over the result. A source read of that word in the replay cycle still returns the result data.
- R7: While dma_ready is low, a DMA request has no effect on memory. dma_ready returns high after any cycle that has no result write.
- R8: A source port whose enable is low keeps its data output unchanged.
- R9: During reset, both source data outputs and dma_rvalid are zero and dma_ready is low. dma_ready rises within a few cycles after reset is released.
- R10: A result write and a DMA write to different words in the same cycle are both stored, and dma_ready stays high.
- R11: The capacity parameter BYTES is a power of two. The byte-address width is log2(BYTES), and the highest word is reachable at byte address BYTES-4 through BYTES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clk2x | input | 1 | Memory clock at twice the system rate, rising edges aligned with clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_en | input | 1 | Source read a request |
| src_a_addr | input | AW | Source read a byte address |
| src_a_data | output | 32 | Source read a data |
| src_b_en | input | 1 | Source read b request |
| src_b_addr | input | AW | Source read b byte address |
| src_b_data | output | 32 | Source read b data |
| res_en | input | 1 | Result write request |
| res_addr | input | AW | Result write byte address |
| res_be | input | 4 | Result write byte-lane enables |
| res_data | input | 32 | Result write data |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA access is a write when high |
| dma_addr | input | AW | DMA byte address |
| dma_be | input | 4 | DMA write byte-lane enables |
| dma_wdata | input | 32 | DMA write data |
| dma_ready | output | 1 | DMA requests are accepted in this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 32 | DMA read data |

## Verification
The bench builds the block with BYTES set to 256. This gives 64 words and an 8-bit address, so the top word at 0xFC to 0xFF is reached directly next to low words, and the address range is covered with few vectors. The 32-bit data width and 4-lane byte enables are fixed, so every lane pattern used in the tests exercises the real packing. With the small capacity, the same-word collision between the result write and a DMA write, and the replay that follows it, can be set up in a few cycles.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int SP_DW    = 32;
  localparam int SP_LANES = SP_DW / 8;

  // which half of the system cycle the memory clock edge serves
  typedef enum logic {
    PH_SRC = 1'b0,
    PH_UPD = 1'b1
  } sp_phase_e;

  // one access on a physical RAM port
  typedef struct packed {
    logic                en;
    logic                we;
    logic [SP_LANES-1:0] be;
    logic [SP_DW-1:0]    wdata;
  } sp_op_t;

endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/sp_phase.sv
module sp_phase
  import sp_pkg::*;
(
  input  logic      clk,
  input  logic      clk2x,
  input  logic      rst_s_n,
  input  logic      rst_f_n,
  output logic      live,
  output sp_phase_e phase
);

  logic tog_q;
  logic tog_f_q;

  // system-clock toggle; starts with live so the first live cycle is phased right
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tog_q <= 1'b0;
      live  <= 1'b0;
    end else begin
      tog_q <= ~tog_q;
      live  <= 1'b1;
    end
  end

  // fast copy lags by one fast edge: differs only at the mid-cycle edge
  always_ff @(posedge clk2x or negedge rst_f_n) begin
    if (!rst_f_n) tog_f_q <= 1'b0;
    else          tog_f_q <= tog_q;
  end

  assign phase = (tog_q != tog_f_q) ? PH_SRC : PH_UPD;

endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import sp_pkg::*;
#(
  parameter int IW    = 9,
  localparam int WORDS = 1 << IW
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  sp_op_t           p0_op,
  input  logic [IW-1:0]    p0_idx,
  output logic [SP_DW-1:0] p0_q,
  input  sp_op_t           p1_op,
  input  logic [IW-1:0]    p1_idx,
  output logic [SP_DW-1:0] p1_q
);

  logic [SP_DW-1:0] mem [WORDS];

  // port 0 is written last so it wins if both ever hit one word
  always_ff @(posedge clk2x) begin
    if (p1_op.en && p1_op.we) begin
      for (int b = 0; b < SP_LANES; b++) begin
        if (p1_op.be[b]) mem[p1_idx][8*b +: 8] <= p1_op.wdata[8*b +: 8];
      end
    end
    if (p0_op.en && p0_op.we) begin
      for (int b = 0; b < SP_LANES; b++) begin
        if (p0_op.be[b]) mem[p0_idx][8*b +: 8] <= p0_op.wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= '0;
      p1_q <= '0;
    end else begin
      if (p0_op.en && !p0_op.we) p0_q <= mem[p0_idx];
      if (p1_op.en && !p1_op.we) p1_q <= mem[p1_idx];
    end
  end

endmodule

// File: rtl/sp_dma_slot.sv
module sp_dma_slot
  import sp_pkg::*;
#(
  parameter int IW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                live,
  input  logic                res_en,
  input  logic [IW-1:0]       res_idx,
  input  logic                dma_req,
  input  logic                dma_we,
  input  logic [IW-1:0]       dma_idx,
  input  logic [SP_LANES-1:0] dma_be,
  input  logic [SP_DW-1:0]    dma_wdata,
  output logic                dma_ready,
  output sp_op_t              upd_op,
  output logic [IW-1:0]       upd_idx,
  output logic                rd_go
);

  logic                slot_v_q,  slot_v_d;
  logic [IW-1:0]       slot_idx_q, slot_idx_d;
  logic [SP_LANES-1:0] slot_be_q,  slot_be_d;
  logic [SP_DW-1:0]    slot_wd_q,  slot_wd_d;

  logic res_live;
  logic new_ok;
  logic new_hit;
  logic old_hit;

  assign res_live  = live & res_en;
  assign dma_ready = live & ~slot_v_q;
  assign new_ok    = dma_ready & dma_req;
  assign new_hit   = new_ok & dma_we & res_live & (res_idx == dma_idx);
  assign old_hit   = slot_v_q & res_live & (res_idx == slot_idx_q);
  assign rd_go     = new_ok & ~dma_we;

  // command for the DMA-side physical port in the update half
  always_comb begin
    upd_op  = '0;
    upd_idx = dma_idx;
    if (slot_v_q) begin
      upd_idx = slot_idx_q;
      if (!old_hit) begin
        upd_op.en    = 1'b1;
        upd_op.we    = 1'b1;
        upd_op.be    = slot_be_q;
        upd_op.wdata = slot_wd_q;
      end
    end else if (new_ok && !new_hit) begin
      upd_op.en    = 1'b1;
      upd_op.we    = dma_we;
      upd_op.be    = dma_be;
      upd_op.wdata = dma_wdata;
    end
  end

  always_comb begin
    slot_v_d   = slot_v_q ? old_hit : new_hit;
    slot_idx_d = slot_idx_q;
    slot_be_d  = slot_be_q;
    slot_wd_d  = slot_wd_q;
    if (!slot_v_q && new_hit) begin
      slot_idx_d = dma_idx;
      slot_be_d  = dma_be;
      slot_wd_d  = dma_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q   <= 1'b0;
      slot_idx_q <= '0;
      slot_be_q  <= '0;
      slot_wd_q  <= '0;
    end else begin
      slot_v_q   <= slot_v_d;
      slot_idx_q <= slot_idx_d;
      slot_be_q  <= slot_be_d;
      slot_wd_q  <= slot_wd_d;
    end
  end

endmodule

// File: rtl/sp_scratch_dp.sv
module sp_scratch_dp
  import sp_pkg::*;
#(
  parameter int BYTES = 2048,
  localparam int AW   = $clog2(BYTES),
  localparam int IW   = AW - 2
) (
  input  logic                clk,
  input  logic                clk2x,
  input  logic                rst_n,
  input  logic                src_a_en,
  input  logic [AW-1:0]       src_a_addr,
  output logic [SP_DW-1:0]    src_a_data,
  input  logic                src_b_en,
  input  logic [AW-1:0]       src_b_addr,
  output logic [SP_DW-1:0]    src_b_data,
  input  logic                res_en,
  input  logic [AW-1:0]       res_addr,
  input  logic [SP_LANES-1:0] res_be,
  input  logic [SP_DW-1:0]    res_data,
  input  logic                dma_req,
  input  logic                dma_we,
  input  logic [AW-1:0]       dma_addr,
  input  logic [SP_LANES-1:0] dma_be,
  input  logic [SP_DW-1:0]    dma_wdata,
  output logic                dma_ready,
  output logic                dma_rvalid,
  output logic [SP_DW-1:0]    dma_rdata
);

  logic      rst_s_n;
  logic      rst_f_n;
  logic      live;
  sp_phase_e phase;

  logic [IW-1:0] src_a_idx, src_b_idx, res_idx, dma_idx;
  logic          unused_lsb;

  sp_op_t           p0_op, p1_op, upd_op;
  logic [IW-1:0]    p0_idx, p1_idx, upd_idx;
  logic [SP_DW-1:0] p0_q, p1_q;
  logic [SP_DW-1:0] dma_hold_q;
  logic             rd_go;
  logic             rd_pend_q;

  assign src_a_idx  = src_a_addr[AW-1:2];
  assign src_b_idx  = src_b_addr[AW-1:2];
  assign res_idx    = res_addr[AW-1:2];
  assign dma_idx    = dma_addr[AW-1:2];
  assign unused_lsb = ^{src_a_addr[1:0], src_b_addr[1:0], res_addr[1:0], dma_addr[1:0]};

  sp_rst_sync u_rst_s (.clk(clk),   .arst_n(rst_n), .srst_n(rst_s_n));
  sp_rst_sync u_rst_f (.clk(clk2x), .arst_n(rst_n), .srst_n(rst_f_n));

  sp_phase u_phase (
    .clk(clk), .clk2x(clk2x), .rst_s_n(rst_s_n), .rst_f_n(rst_f_n),
    .live(live), .phase(phase)
  );

  sp_dma_slot #(.IW(IW)) u_slot (
    .clk(clk), .rst_n(rst_s_n), .live(live),
    .res_en(res_en), .res_idx(res_idx),
    .dma_req(dma_req), .dma_we(dma_we), .dma_idx(dma_idx),
    .dma_be(dma_be), .dma_wdata(dma_wdata),
    .dma_ready(dma_ready), .upd_op(upd_op), .upd_idx(upd_idx), .rd_go(rd_go)
  );

  // steer the two physical ports by fast half
  always_comb begin
    p0_op  = '0;
    p1_op  = '0;
    p0_idx = src_a_idx;
    p1_idx = src_b_idx;
    if (phase == PH_SRC) begin
      p0_op.en = live & src_a_en;
      p1_op.en = live & src_b_en;
    end else begin
      p0_op.en    = live & res_en;
      p0_op.we    = 1'b1;
      p0_op.be    = res_be;
      p0_op.wdata = res_data;
      p0_idx      = res_idx;
      p1_op       = upd_op;
      p1_idx      = upd_idx;
    end
  end

  sp_bank #(.IW(IW)) u_bank (
    .clk2x(clk2x), .rst_n(rst_f_n),
    .p0_op(p0_op), .p0_idx(p0_idx), .p0_q(p0_q),
    .p1_op(p1_op), .p1_idx(p1_idx), .p1_q(p1_q)
  );

  // DMA read word is caught before the next source-read half overwrites it
  always_ff @(posedge clk2x or negedge rst_f_n) begin
    if (!rst_f_n) begin
      dma_hold_q <= '0;
    end else if (phase == PH_SRC && rd_pend_q) begin
      dma_hold_q <= p1_q;
    end
  end

  // system-clock alignment of all read results
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      src_a_data <= '0;
      src_b_data <= '0;
      rd_pend_q  <= 1'b0;
      dma_rvalid <= 1'b0;
      dma_rdata  <= '0;
    end else begin
      if (live && src_a_en) src_a_data <= p0_q;
      if (live && src_b_en) src_b_data <= p1_q;
      rd_pend_q  <= rd_go;
      dma_rvalid <= rd_pend_q;
      if (rd_pend_q) dma_rdata <= dma_hold_q;
    end
  end

endmodule

// File: rtl/sp_scratch_chk.sv
module sp_scratch_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          live,
  input logic          src_a_en,
  input logic [31:0]   src_a_data,
  input logic          src_b_en,
  input logic [31:0]   src_b_data,
  input logic          res_en,
  input logic [AW-1:0] res_addr,
  input logic          dma_req,
  input logic          dma_we,
  input logic [AW-1:0] dma_addr,
  input logic          dma_ready,
  input logic          dma_rvalid
);

  logic same_word;
  logic rd_seen1_q;
  logic rd_seen2_q;

  assign same_word = res_addr[AW-1:2] == dma_addr[AW-1:2];

  always_ff @(posedge clk) begin
    if (!live) begin
      rd_seen1_q <= 1'b0;
      rd_seen2_q <= 1'b0;
    end else begin
      rd_seen1_q <= dma_req && !dma_we && dma_ready;
      rd_seen2_q <= rd_seen1_q;
    end
  end

  // R6
  res_wins_stall_chk: assert property (@(posedge clk) disable iff (!live)
    res_en && dma_req && dma_we && dma_ready && same_word |=> !dma_ready);

  // R7
  ready_returns_chk: assert property (@(posedge clk) disable iff (!live)
    !dma_ready && !res_en |=> dma_ready);

  // R10
  no_false_stall_chk: assert property (@(posedge clk) disable iff (!live)
    dma_ready && !(res_en && dma_req && dma_we && same_word) |=> dma_ready);

  // R5
  dma_read_lat_chk: assert property (@(posedge clk) disable iff (!live)
    dma_req && !dma_we && dma_ready |=> ##1 dma_rvalid);

  // R5
  rvalid_origin_chk: assert property (@(posedge clk) disable iff (!live)
    dma_rvalid |-> rd_seen2_q);

  // R8
  src_a_hold_chk: assert property (@(posedge clk) disable iff (!live)
    !src_a_en |=> $stable(src_a_data));

  // R8
  src_b_hold_chk: assert property (@(posedge clk) disable iff (!live)
    !src_b_en |=> $stable(src_b_data));

endmodule

bind sp_scratch_dp sp_scratch_chk #(.AW(AW)) u_chk (
  .clk(clk), .live(live),
  .src_a_en(src_a_en), .src_a_data(src_a_data),
  .src_b_en(src_b_en), .src_b_data(src_b_data),
  .res_en(res_en), .res_addr(res_addr),
  .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
  .dma_ready(dma_ready), .dma_rvalid(dma_rvalid)
);

// File: tb/tb_sp_scratch_dp.sv
module tb_sp_scratch_dp;

  localparam int TB_BYTES = 256;
  localparam int AW = 8;

  logic clk, clk2x, rst_n;
  logic          src_a_en, src_b_en, res_en, dma_req, dma_we;
  logic [AW-1:0] src_a_addr, src_b_addr, res_addr, dma_addr;
  logic [3:0]    res_be, dma_be;
  logic [31:0]   res_data, dma_wdata, src_a_data, src_b_data, dma_rdata;
  logic          dma_ready, dma_rvalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  sp_scratch_dp #(.BYTES(TB_BYTES)) dut (.*);

  // 50 MHz system clock; fast clock rises with it in the same process
  initial begin
    clk = 0; clk2x = 0;
    forever begin
      #5  clk2x = 1; clk = ~clk;
      #5  clk2x = 0;
    end
  end

  typedef struct packed {
    logic        we;  logic [7:0] wa; logic [3:0] be; logic [31:0] wd;
    logic        ae;  logic [7:0] aa;
    logic        bn;  logic [7:0] ba;
    logic [31:0] xa;  logic [31:0] xb;
  } row_t;

  // rows exercise R1, R2, R3, R8, R11
  localparam row_t TBL [7] = '{
    '{1'b1, 8'h10, 4'hF, 32'h11223344, 1'b0, 8'h00, 1'b0, 8'h00, 32'h0,        32'h0},
    '{1'b1, 8'h14, 4'hF, 32'hA5A5A5A5, 1'b1, 8'h10, 1'b0, 8'h00, 32'h11223344, 32'h0},
    '{1'b1, 8'h10, 4'h5, 32'hFFEEDDCC, 1'b1, 8'h13, 1'b1, 8'h14, 32'h11223344, 32'hA5A5A5A5},
    '{1'b0, 8'h00, 4'h0, 32'h0,        1'b1, 8'h10, 1'b1, 8'h11, 32'h11EE33CC, 32'h11EE33CC},
    '{1'b1, 8'hFC, 4'hF, 32'h0BADF00D, 1'b0, 8'h00, 1'b1, 8'h14, 32'h11EE33CC, 32'hA5A5A5A5},
    '{1'b1, 8'h14, 4'hA, 32'h12345678, 1'b1, 8'hFC, 1'b0, 8'h00, 32'h0BADF00D, 32'hA5A5A5A5},
    '{1'b0, 8'h00, 4'h0, 32'h0,        1'b1, 8'h14, 1'b1, 8'hFF, 32'h12A556A5, 32'h0BADF00D}
  };

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    src_a_en = 0; src_a_addr = '0; src_b_en = 0; src_b_addr = '0;
    res_en = 0; res_addr = '0; res_be = '0; res_data = '0;
    dma_req = 0; dma_we = 0; dma_addr = '0; dma_be = '0; dma_wdata = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (4) step();
    // R9 reset state
    chk("R9 src_a_data in reset", src_a_data, 32'h0);
    chk("R9 src_b_data in reset", src_b_data, 32'h0);
    chk("R9 dma_rvalid in reset", {31'b0, dma_rvalid}, 32'h0);
    chk("R9 dma_ready in reset",  {31'b0, dma_ready},  32'h0);
    rst_n = 1;
    for (int i = 0; i < 8 && !dma_ready; i++) step();
    chk("R9 dma_ready after reset", {31'b0, dma_ready}, 32'h1);

    // vector table
    for (int i = 0; i < 7; i++) begin
      res_en = TBL[i].we; res_addr = TBL[i].wa; res_be = TBL[i].be; res_data = TBL[i].wd;
      src_a_en = TBL[i].ae; src_a_addr = TBL[i].aa;
      src_b_en = TBL[i].bn; src_b_addr = TBL[i].ba;
      step();
      chk($sformatf("R1/R2/R3/R8/R11 row %0d port a", i), src_a_data, TBL[i].xa);
      chk($sformatf("R1/R2/R3/R8/R11 row %0d port b", i), src_b_data, TBL[i].xb);
    end
    idle();

    // R4 DMA writes with lane enables
    dma_req = 1; dma_we = 1; dma_addr = 8'h20; dma_be = 4'hF; dma_wdata = 32'hCAFEBABE;
    step();
    dma_be = 4'h3; dma_wdata = 32'h00001234;
    step();
    chk("R4 dma_ready during DMA writes", {31'b0, dma_ready}, 32'h1);
    idle(); src_a_en = 1; src_a_addr = 8'h20;
    step();
    chk("R4 DMA merged word", src_a_data, 32'hCAFE1234);

    // R5 DMA read latency
    idle(); dma_req = 1; dma_addr = 8'h21;
    step();
    chk("R5 rvalid after one edge", {31'b0, dma_rvalid}, 32'h0);
    idle();
    step();
    chk("R5 rvalid after two edges", {31'b0, dma_rvalid}, 32'h1);
    chk("R5 dma_rdata", dma_rdata, 32'hCAFE1234);
    step();
    chk("R5 rvalid single cycle", {31'b0, dma_rvalid}, 32'h0);

    // R10 different words in one cycle
    res_en = 1; res_addr = 8'h30; res_be = 4'hF; res_data = 32'h00000001;
    dma_req = 1; dma_we = 1; dma_addr = 8'h34; dma_be = 4'hF; dma_wdata = 32'h00000002;
    step();
    chk("R10 no stall", {31'b0, dma_ready}, 32'h1);
    idle(); src_a_en = 1; src_a_addr = 8'h30; src_b_en = 1; src_b_addr = 8'h34;
    step();
    chk("R10 result word", src_a_data, 32'h00000001);
    chk("R10 DMA word", src_b_data, 32'h00000002);

    // R6 same-word collision
    idle();
    res_en = 1; res_addr = 8'h40; res_be = 4'hF; res_data = 32'h11111111;
    dma_req = 1; dma_we = 1; dma_addr = 8'h42; dma_be = 4'hC; dma_wdata = 32'hAABB0000;
    step();
    chk("R6 ready low after collision", {31'b0, dma_ready}, 32'h0);
    idle(); src_a_en = 1; src_a_addr = 8'h40;
    step();
    chk("R6 result stored first", src_a_data, 32'h11111111);
    chk("R6 ready back", {31'b0, dma_ready}, 32'h1);
    step();
    chk("R6 DMA replay on top", src_a_data, 32'hAABB1111);

    // R7 request ignored while not ready
    idle(); res_en = 1; res_addr = 8'h60; res_be = 4'hF; res_data = 32'h0;
    step();
    res_addr = 8'h50;
    dma_req = 1; dma_we = 1; dma_addr = 8'h50; dma_be = 4'hF; dma_wdata = 32'h99999999;
    step();
    chk("R7 ready low", {31'b0, dma_ready}, 32'h0);
    idle(); dma_req = 1; dma_we = 1; dma_addr = 8'h60; dma_be = 4'hF; dma_wdata = 32'hDEADBEEF;
    step();
    idle(); src_a_en = 1; src_a_addr = 8'h60; src_b_en = 1; src_b_addr = 8'h50;
    step();
    chk("R7 refused write left word", src_a_data, 32'h00000000);
    chk("R7 replayed write stored", src_b_data, 32'h99999999);

    idle();
    step();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule